// File: doc/BRIEF.md
# E1 CRC-4 Framed Test Pattern Generator

This block produces a serial 2.048 Mbit/s E1 test stream, one bit per clock. With framing disabled, every bit is taken from a 2^15-1 pseudo-random sequence. With framing enabled, the same sequence fills the payload timeslots of a 256-bit frame. The generator builds timeslot 0 itself: the alignment word, the non-alignment word, the spare-bit pattern, the E bits and the CRC-4 check bits of a 16-frame multiframe. Timeslot 16 holds fixed all-ones signalling.

Two controls support tests of a receiver. The first replaces the alignment word with a copy whose last bit is flipped, which a receiver sees as a framing error. The second injects a single CRC-4 error each time its input goes from low to high. A launch stage sends the data and the frame-sync pulse on either edge of the bit clock. The core always runs on the rising edge.

Top module: `e1_crc4_patgen`

## Requirements
- R1: While `rst_n` is low, `ser_data` and `frame_sync` are both 0.
- R2: With `frame_en` = 0, every bit is the next bit of a PRBS with polynomial x^15+x^14+1. The 15-bit register is seeded with all ones, the output is its most significant bit, and the sequence is not inverted.
- R3: `frame_sync` is 1 together with the first bit of every 256-bit frame and 0 on all other bits. The first frame after reset is frame 0 of a multiframe.
- R4: With `frame_en` = 1 and `fas_inv` = 0, bit positions 1..7 of timeslot 0 in even frames carry 0011011, sent left to right. Position 0 is the first bit sent.
- R5: With `fas_inv` = 1, those seven positions carry 0011010.
- R6: In odd frames, positions 1..7 of timeslot 0 carry 1011111, sent left to right.
- R7: Position 0 of timeslot 0 in odd frames 1, 3, 5, 7, 9 and 11 carries 0, 0, 1, 0, 1, 1 in that order. In frames 13 and 15 it carries 1.
- R8: Position 0 of timeslot 0 in even frames 0/2/4/6 of a half-multiframe (frames 0-7 or 8-15) carries C1..C4. These bits are the CRC-4 remainder of the previous half-multiframe, C1 first. The remainder uses polynomial x^4+x+1 with a zero start, is fed in transmission order, and counts each C-bit position as 0. The first half after reset sends 0000.
- R9: When framed, timeslot 16 (bits 128..135 of a frame) is all ones. The other 30 timeslots carry the PRBS of R2, which advances only on those payload bits.
- R10: A 0-to-1 change of `crc_err_ins` inverts all four C bits of exactly one later half-multiframe. That half carries the remainder computed over the half in which the change was seen. Holding the input high, or lowering it, corrupts nothing.
- R11: With `edge_rise` = 1, the outputs change just after the rising clock edge. With `edge_rise` = 0, they carry the same sequence but change just after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 2.048 MHz in use |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| edge_rise | input | 1 | 1: launch on the rising edge, 0: launch on the falling edge |
| frame_en | input | 1 | 1: framed CRC-4 multiframe, 0: unframed PRBS |
| fas_inv | input | 1 | Flips the last bit of the alignment word |
| crc_err_ins | input | 1 | Each rising transition injects one CRC-4 error |
| ser_data | output | 1 | Serial test data |
| frame_sync | output | 1 | High with the first bit of every frame |

## Verification
The hardest case to reach is R10, which depends on where in the multiframe the error-insert input changes. The stimulus counts bits from reset release. It raises the input in the middle of the third half-multiframe and holds it high across several later boundaries. It then drops the input and raises it again inside the seventh half. The reference model therefore expects inverted C bits in exactly two halves, and unchanged C bits in the halves where the input stayed high. The falling-edge mode is checked by sampling each bit both shortly after the rising edge and just before the next one.

// File: rtl/e1pg_pkg.sv
`timescale 1ns/1ps
package e1pg_pkg;
  // frame geometry
  localparam int SLOT_BITS    = 8;
  localparam int SIG_SLOT     = 16;
  localparam int HALF_FRAMES  = 8;
  // timeslot 0 words, leftmost bit sent first
  localparam logic [6:0] ALIGN_WORD  = 7'b0011011;
  localparam logic [6:0] NALIGN_WORD = 7'b1011111;
  localparam logic [5:0] SPARE_SEQ   = 6'b001011;
  localparam int         SPARE_LAST_FRAME = 11;
  // CRC-4: x^4 + x + 1, low terms only
  localparam int         CRC_W    = 4;
  localparam logic [3:0] CRC_POLY = 4'b0011;
  // PRBS 2^15-1: x^15 + x^14 + 1
  localparam int PRBS_LEN = 15;
  localparam int PRBS_TAP = 14;

  typedef enum logic [2:0] {
    SRC_PRBS,
    SRC_CBIT,
    SRC_SPARE,
    SRC_WORD,
    SRC_SIG
  } bit_src_e;
endpackage

// File: rtl/e1pg_timing.sv
`timescale 1ns/1ps
module e1pg_timing #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16,
  parameter int FRAMES_PER_HALF = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [$clog2(BITS_PER_FRAME)-1:0] bit_idx,
  output logic [$clog2(FRAMES_PER_MF)-1:0]  frm_idx,
  output logic                              frame_start,
  output logic                              half_end
);
  localparam int BW = $clog2(BITS_PER_FRAME);
  localparam int FW = $clog2(FRAMES_PER_MF);
  localparam int HW = $clog2(FRAMES_PER_HALF);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_FRAME - 1);
  localparam logic [FW-1:0] LAST_FRM = FW'(FRAMES_PER_MF - 1);

  logic [BW-1:0] bit_d;
  logic [FW-1:0] frm_d;
  logic          frame_end;

  assign frame_end   = (bit_idx == LAST_BIT);
  assign frame_start = (bit_idx == '0);
  assign half_end    = frame_end && (frm_idx[HW-1:0] == {HW{1'b1}});

  always_comb begin
    bit_d = frame_end ? '0 : bit_idx + 1'b1;
    frm_d = frm_idx;
    if (frame_end) begin
      frm_d = (frm_idx == LAST_FRM) ? '0 : frm_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      frm_idx <= '0;
    end else begin
      bit_idx <= bit_d;
      frm_idx <= frm_d;
    end
  end
endmodule

// File: rtl/e1pg_prbs.sv
`timescale 1ns/1ps
module e1pg_prbs #(
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic prbs_bit
);
  logic [LEN-1:0] st_q, st_d;

  assign prbs_bit = st_q[LEN-1];

  always_comb begin
    st_d = st_q;
    if (adv) begin
      st_d = {st_q[LEN-2:0], st_q[LEN-1] ^ st_q[TAP-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/e1pg_crc4.sv
`timescale 1ns/1ps
module e1pg_crc4 #(
  parameter int            W    = 4,
  parameter logic [W-1:0]  POLY = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic         zero_in,
  input  logic         half_end,
  input  logic         ins_req,
  output logic [W-1:0] crc_word
);
  logic [W-1:0] acc_q, acc_d, send_d, step;
  logic         ins_q, pend_q, pend_d, rise, fb;

  assign fb   = (zero_in ? 1'b0 : din) ^ acc_q[W-1];
  assign step = {acc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  assign rise = ins_req & ~ins_q;

  always_comb begin
    acc_d  = step;
    send_d = crc_word;
    pend_d = pend_q | rise;
    if (half_end) begin
      acc_d  = '0;
      send_d = step ^ {W{pend_q}};
      pend_d = rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      crc_word <= '0;
      ins_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      crc_word <= send_d;
      ins_q    <= ins_req;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/e1pg_launch.sv
`timescale 1ns/1ps
module e1pg_launch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_rise,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic pos_q, neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= 1'b0;
      else        pos_q <= d[g];
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= pos_q;
    end

    assign q[g] = edge_rise ? pos_q : neg_q;
  end
endmodule

// File: rtl/e1_crc4_patgen.sv
`timescale 1ns/1ps
module e1_crc4_patgen
  import e1pg_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_rise,
  input  logic frame_en,
  input  logic fas_inv,
  input  logic crc_err_ins,
  output logic ser_data,
  output logic frame_sync
);
  localparam int BW  = $clog2(BITS_PER_FRAME);
  localparam int FW  = $clog2(FRAMES_PER_MF);
  localparam int SBW = $clog2(SLOT_BITS);
  localparam int TW  = BW - SBW;

  logic [BW-1:0]    bit_idx;
  logic [FW-1:0]    frm_idx;
  logic             frame_start, half_end;
  logic             prbs_bit, prbs_adv;
  logic [CRC_W-1:0] crc_word;
  logic             tx_bit, c_pos;
  logic [TW-1:0]    slot;
  logic [SBW-1:0]   sub;
  logic [6:0]       align_eff;
  bit_src_e         src;
  logic [1:0]       lane_d, lane_q;

  e1pg_timing #(
    .BITS_PER_FRAME (BITS_PER_FRAME),
    .FRAMES_PER_MF  (FRAMES_PER_MF),
    .FRAMES_PER_HALF(HALF_FRAMES)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_idx    (bit_idx),
    .frm_idx    (frm_idx),
    .frame_start(frame_start),
    .half_end   (half_end)
  );

  e1pg_prbs #(.LEN(PRBS_LEN), .TAP(PRBS_TAP)) u_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (prbs_adv),
    .prbs_bit(prbs_bit)
  );

  e1pg_crc4 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (tx_bit),
    .zero_in (c_pos),
    .half_end(half_end),
    .ins_req (crc_err_ins),
    .crc_word(crc_word)
  );

  assign slot      = bit_idx[BW-1:SBW];
  assign sub       = bit_idx[SBW-1:0];
  assign align_eff = {ALIGN_WORD[6:1], ALIGN_WORD[0] ^ fas_inv};

  // pick the source of the current bit position
  always_comb begin
    src = SRC_PRBS;
    if (frame_en) begin
      if (slot == '0) begin
        if (sub != '0)        src = SRC_WORD;
        else if (!frm_idx[0]) src = SRC_CBIT;
        else                  src = SRC_SPARE;
      end else if (slot == TW'(SIG_SLOT)) begin
        src = SRC_SIG;
      end
    end
  end

  always_comb begin
    tx_bit   = prbs_bit;
    prbs_adv = 1'b0;
    c_pos    = 1'b0;
    unique case (src)
      SRC_PRBS: prbs_adv = 1'b1;
      SRC_CBIT: begin
        c_pos  = 1'b1;
        tx_bit = crc_word[2'd3 - frm_idx[2:1]];
      end
      SRC_SPARE: begin
        if (int'(frm_idx) <= SPARE_LAST_FRAME) tx_bit = SPARE_SEQ[3'd5 - frm_idx[3:1]];
        else                                   tx_bit = 1'b1;
      end
      SRC_WORD: tx_bit = frm_idx[0] ? NALIGN_WORD[3'd7 - sub] : align_eff[3'd7 - sub];
      SRC_SIG:  tx_bit = 1'b1;
      default:  tx_bit = prbs_bit;
    endcase
  end

  assign lane_d = {frame_start, tx_bit};

  e1pg_launch #(.W(2)) u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_rise(edge_rise),
    .d        (lane_d),
    .q        (lane_q)
  );

  assign ser_data   = lane_q[0];
  assign frame_sync = lane_q[1];
endmodule

// File: rtl/e1pg_checker.sv
`timescale 1ns/1ps
module e1pg_checker #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic frame_en,
  input logic fas_inv,
  input logic ser_data,
  input logic frame_sync
);
  localparam int BW = $clog2(BITS_PER_FRAME);
  localparam int FW = $clog2(FRAMES_PER_MF);
  localparam logic [BW-1:0] LAST = BW'(BITS_PER_FRAME - 1);
  localparam logic [6:0] AW  = 7'b0011011;
  localparam logic [6:0] AWI = 7'b0011010;

  logic          seen;
  logic [BW-1:0] cnt;
  logic [FW-1:0] fcnt;

  // cnt = position-1 of the bit seen on the ports, fcnt = its frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      cnt  <= '0;
      fcnt <= '0;
    end else if (frame_sync) begin
      seen <= 1'b1;
      cnt  <= '0;
      fcnt <= seen ? fcnt + 1'b1 : '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!ser_data && !frame_sync));

  assert_sync_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt == LAST) |-> frame_sync);

  assert_sync_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt != LAST) |-> !frame_sync);

  assert_align_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && frame_en && !fas_inv && !fcnt[0] && cnt < 7) |-> ser_data == AW[3'd6 - cnt[2:0]]);

  assert_align_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && frame_en && fas_inv && !fcnt[0] && cnt < 7) |-> ser_data == AWI[3'd6 - cnt[2:0]]);

  assert_nalign_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && frame_en && fcnt[0] && cnt == '0) |-> ser_data);

  assert_ebits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && frame_en && frame_sync && (int'(fcnt) == 12 || int'(fcnt) == 14)) |-> ser_data);

  assert_sig_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && frame_en && cnt >= BW'(127) && cnt <= BW'(134)) |-> ser_data);
endmodule

bind e1_crc4_patgen e1pg_checker #(
  .BITS_PER_FRAME(BITS_PER_FRAME),
  .FRAMES_PER_MF (FRAMES_PER_MF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_en  (frame_en),
  .fas_inv   (fas_inv),
  .ser_data  (ser_data),
  .frame_sync(frame_sync)
);

// File: tb/tb_e1_crc4_patgen.sv
`timescale 1ns/1ps
module tb_e1_crc4_patgen;
  logic clk, rst_n, edge_rise, frame_en, fas_inv, crc_err_ins;
  logic ser_data, frame_sync;

  int    n_chk, n_fail;
  logic  mon_on;
  logic  prev_bit;
  logic  exp_q[$];
  logic  sync_q[$];
  string tag_q[$];

  e1_crc4_patgen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_rise  (edge_rise),
    .frame_en   (frame_en),
    .fas_inv    (fas_inv),
    .crc_err_ins(crc_err_ins),
    .ser_data   (ser_data),
    .frame_sync (frame_sync)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // driver: reference stream from the requirements
  task automatic build(input logic fe, input logic fi, input int nbits, input int ea, input int eb);
    logic [14:0] s;
    logic [3:0]  acc, snd;
    logic [6:0]  aw, nw;
    logic [5:0]  sp;
    s = '1; acc = '0; snd = '0;
    aw = fi ? 7'b0011010 : 7'b0011011;
    nw = 7'b1011111;
    sp = 6'b001011;
    for (int i = 0; i < nbits; i++) begin
      int    bp, frm, h, ts, sb;
      logic  b, cpos, adv, d, fb, bad;
      string tg;
      bp = i % 256; frm = (i / 256) % 16; h = i / 2048;
      bad = (h - 1 == ea) || (h - 1 == eb);
      if (i > 0 && bp == 0 && (frm % 8) == 0) begin
        snd = acc ^ (bad ? 4'hF : 4'h0);
        acc = '0;
      end
      ts = bp / 8; sb = bp % 8; cpos = 1'b0; adv = 1'b0;
      if (!fe) begin
        b = s[14]; adv = 1'b1; tg = "R2";
      end else if (ts == 0) begin
        if (sb == 0) begin
          if (frm % 2 == 0) begin
            cpos = 1'b1; b = snd[3 - (frm % 8) / 2]; tg = bad ? "R10" : "R8";
          end else if (frm <= 11) begin
            b = sp[5 - (frm - 1) / 2]; tg = "R7";
          end else begin
            b = 1'b1; tg = "R7";
          end
        end else if (frm % 2 == 0) begin
          b = aw[7 - sb]; tg = fi ? "R5" : "R4";
        end else begin
          b = nw[7 - sb]; tg = "R6";
        end
      end else if (ts == 16) begin
        b = 1'b1; tg = "R9";
      end else begin
        b = s[14]; adv = 1'b1; tg = "R9";
      end
      exp_q.push_back(b);
      sync_q.push_back(bp == 0);
      tag_q.push_back(tg);
      d  = cpos ? 1'b0 : b;
      fb = d ^ acc[3];
      acc = {acc[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
      if (adv) s = {s[13:0], s[14] ^ s[13]};
    end
  endtask

  // monitor: pops the scoreboard once per bit
  initial begin
    forever begin
      @(posedge clk);
      if (mon_on && exp_q.size() > 0) begin
        logic  early, late, ls, eb, es;
        string tg;
        #2 early = ser_data;
        #7 late = ser_data;
        ls = frame_sync;
        eb = exp_q.pop_front();
        es = sync_q.pop_front();
        tg = tag_q.pop_front();
        check(late == eb, tg, late, eb);
        check(ls == es, "R3", ls, es);
        // R11: launch edge
        if (edge_rise) check(early == late, "R11", early, late);
        else           check(early == prev_bit, "R11", early, prev_bit);
        prev_bit = late;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  task automatic start_phase(input logic er, input logic fe, input logic fi,
                             input int nbits, input int ea, input int eb);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    crc_err_ins = 1'b0;
    edge_rise = er; frame_en = fe; fas_inv = fi;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(ser_data == 1'b0 && frame_sync == 1'b0, "R1", {ser_data, frame_sync}, 0);
    build(fe, fi, nbits, ea, eb);
    prev_bit = 1'b0;
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; mon_on = 1'b0; prev_bit = 1'b0;
    rst_n = 1'b1; edge_rise = 1'b1; frame_en = 1'b0; fas_inv = 1'b0; crc_err_ins = 1'b0;
    #1 rst_n = 1'b0;

    // framed, normal alignment word: R3 R4 R6 R7 R8 R9
    start_phase(1'b1, 1'b1, 1'b0, 8192, -1, -1);
    drain();
    // framed, inverted alignment word: R5
    start_phase(1'b1, 1'b1, 1'b1, 4096, -1, -1);
    drain();
    // unframed PRBS: R2
    start_phase(1'b1, 1'b0, 1'b0, 3000, -1, -1);
    drain();
    // error insertion: R10, corrupted halves 3 and 7
    start_phase(1'b1, 1'b1, 1'b0, 20480, 2, 6);
    repeat (4608) @(negedge clk);
    crc_err_ins = 1'b1;
    repeat (6400) @(negedge clk);
    crc_err_ins = 1'b0;
    repeat (1792) @(negedge clk);
    crc_err_ins = 1'b1;
    drain();
    // falling-edge launch: R11
    start_phase(1'b0, 1'b1, 1'b0, 4096, -1, -1);
    drain();

    summary();
    $finish;
  end
endmodule